// File: doc/BRIEF.md
# Negative-Delta-V and Flat-Voltage Charge Terminator

This block watches one nickel-chemistry cell during fast charge and decides when fast charge is over. It receives a level that is high while the cell's charge controller has the cell in fast charge, a tick for every charge slot that belongs to the cell, and a strobe carrying an unsigned open-circuit voltage code from the converter. It answers with a single-cycle termination pulse and a one-bit reason. The charge controller uses that pulse to move the cell on to its top-off phase.

Raising the fast-charge level starts a blanking period that is counted in slot ticks. During this period samples are thrown away, so the voltage swings of the first few minutes cannot end the charge. When the blanking period is over, the block opens a window on every `SAMPLE_EVERY`-th slot. This is the slot in which the cell gets no current. The block takes the first voltage sample that arrives in that window. It keeps a running peak of the accepted samples and ends the charge for one of two reasons. The voltage can fall a set number of LSBs below the peak. The peak can also fail to rise for `FLAT_SAMPLES` accepted samples in a row. With the default values, the blanking period is about 4 minutes, samples are about 31 seconds apart, and the plateau limit is about 16 minutes.

Top module: `ndv_term_detect`

## Requirements
- R1: Reset behaviour. After reset, and at any time while `fast_en` is low, `term_o` and `term_reason_o` are 0, and no sample, slot tick or voltage code can make either of them 1.
- R2: Blanking period. After `fast_en` rises, samples are ignored until `HOLD_SLOTS` slot ticks have been seen with `fast_en` high, and no termination is signalled in that time.
- R3: Sample window. After the blanking period, the window is open from the (`SAMPLE_EVERY`-1)-th slot tick after the blanking period ends until the next slot tick. The window then opens again every `SAMPLE_EVERY` ticks. Only the first `smp_valid` strobe inside an open window is accepted. Strobes outside the window, and later strobes in the same window, are ignored.
- R4: Peak tracking. The first accepted sample of a session becomes the peak. A later accepted sample that is strictly greater than the peak replaces it. An equal or smaller sample leaves the peak as it is.
- R5: Drop detection. An accepted sample that is at least `DROP_LSB` codes below the peak ends the charge with reason 0 (drop). `term_o` is high in the cycle after the clock edge that accepted the sample. A shortfall of `DROP_LSB`-1 codes does not end the charge.
- R6: Plateau detection. If the peak is not replaced for `FLAT_SAMPLES` accepted samples in a row, the last of these samples ends the charge with reason 1 (flat).
- R7: Plateau restart. Each new peak restarts the plateau count from zero. A sample equal to the peak does not restart the count.
- R8: Priority. When one sample meets both the drop condition and the plateau condition, the reason reported is 0 (drop).
- R9: Single pulse. `term_o` is high for exactly one cycle. After a termination, no further sample of the same session can produce another pulse.
- R10: Session restart. When `fast_en` goes low, the peak, the plateau count, the blanking timer and the terminated state are all cleared. A new session starts with a full blanking period and no memory of the earlier peak.
- R11: Gating. If `fast_en` goes low in the cycle where a pulse would appear, `term_o` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fast_en | input | 1 | High while the cell is in fast charge |
| slot_tick | input | 1 | One-cycle strobe at each charge slot of this cell |
| smp_valid | input | 1 | One-cycle strobe: `smp_code` holds a new open-circuit sample |
| smp_code | input | CODE_W | Unsigned cell voltage code |
| term_o | output | 1 | One-cycle pulse: fast charge must end |
| term_reason_o | output | 1 | Reason, valid with `term_o`: 0 = drop, 1 = flat |

## Verification
Any wrong internal state in this block can only be seen through the timing and reason of the single termination pulse. A peak register that is wrong, or that fails to clear, shows up at the next accepted sample. Such a sample then causes a drop termination that should not happen, or misses one that should, within one sample period. A blanking counter or window phase that is off by one slot lets a planted sample that should be discarded change the peak. The next window then exposes that change as a wrong drop decision. A plateau count that is off by one moves the flat pulse by one whole sample period. The stimulus therefore lines up each expected pulse on an exact sample and checks the sample before it as well.

// File: rtl/ndv_pkg.sv
package ndv_pkg;

  typedef enum logic {
    NDV_DROP = 1'b0,
    NDV_FLAT = 1'b1
  } ndv_reason_e;

  // sample strictly above current peak
  function automatic logic ndv_rises(input int unsigned sample, input int unsigned peak);
    return sample > peak;
  endfunction

  // sample sits at least thr codes under peak
  function automatic logic ndv_dropped(input int unsigned sample, input int unsigned peak,
                                       input int unsigned thr);
    if (sample >= peak) return 1'b0;
    return (peak - sample) >= thr;
  endfunction

endpackage

// File: rtl/ndv_slot_timer.sv
module ndv_slot_timer #(
  parameter int HOLD_SLOTS   = 125,
  parameter int SAMPLE_EVERY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_en,
  input  logic slot_tick,
  output logic holdoff_done,
  output logic sample_win
);
  localparam int HW = $clog2(HOLD_SLOTS + 1);
  localparam int PW = (SAMPLE_EVERY > 2) ? $clog2(SAMPLE_EVERY) : 1;
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_SLOTS);
  localparam logic [PW-1:0] PH_LAST  = PW'(SAMPLE_EVERY - 1);

  logic [HW-1:0] hold_cnt;
  logic [PW-1:0] phase;

  assign holdoff_done = (hold_cnt == HOLD_END);
  assign sample_win   = holdoff_done && (phase == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (!fast_en) begin
      hold_cnt <= '0;
    end else if (slot_tick && !holdoff_done) begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!fast_en || !holdoff_done) begin
      phase <= '0;
    end else if (slot_tick) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

endmodule

// File: rtl/ndv_peak_tracker.sv
module ndv_peak_tracker #(
  parameter int CODE_W   = 12,
  parameter int DROP_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              accept,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] peak,
  output logic              have_peak,
  output logic              new_peak,
  output logic              drop_hit
);
  import ndv_pkg::*;

  logic rises, falls;

  assign rises    = ndv_rises(32'(code), 32'(peak));
  assign falls    = ndv_dropped(32'(code), 32'(peak), 32'(DROP_LSB));
  assign new_peak = accept && (!have_peak || rises);
  assign drop_hit = accept && have_peak && falls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak      <= '0;
      have_peak <= 1'b0;
    end else if (clear) begin
      peak      <= '0;
      have_peak <= 1'b0;
    end else if (new_peak) begin
      peak      <= code;
      have_peak <= 1'b1;
    end
  end

endmodule

// File: rtl/ndv_flat_counter.sv
module ndv_flat_counter #(
  parameter int FLAT_SAMPLES = 31,
  localparam int FW = (FLAT_SAMPLES > 2) ? $clog2(FLAT_SAMPLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          accept,
  input  logic          restart,
  output logic [FW-1:0] flat_cnt,
  output logic          flat_hit
);
  localparam logic [FW-1:0] CNT_LAST = FW'(FLAT_SAMPLES - 1);

  assign flat_hit = accept && !restart && (flat_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flat_cnt <= '0;
    end else if (clear) begin
      flat_cnt <= '0;
    end else if (accept) begin
      if (restart)                    flat_cnt <= '0;
      else if (flat_cnt != CNT_LAST)  flat_cnt <= flat_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ndv_term_detect.sv
module ndv_term_detect #(
  parameter int CODE_W       = 12,
  parameter int HOLD_SLOTS   = 125,
  parameter int SAMPLE_EVERY = 16,
  parameter int FLAT_SAMPLES = 31,
  parameter int DROP_LSB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_en,
  input  logic              slot_tick,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  output logic              term_o,
  output logic              term_reason_o
);
  import ndv_pkg::*;

  localparam int FW = (FLAT_SAMPLES > 2) ? $clog2(FLAT_SAMPLES) : 1;

  // named internal events
  logic              holdoff_done;
  logic              sample_win;
  logic              accept;
  logic              new_peak;
  logic              drop_hit;
  logic              flat_hit;
  logic              have_peak;
  logic [CODE_W-1:0] peak;
  logic [FW-1:0]     flat_cnt;
  logic              clear;

  logic        taken;
  logic        done;
  logic        term_q;
  ndv_reason_e reason_q;

  assign clear  = !fast_en;
  assign accept = fast_en && sample_win && smp_valid && !taken && !done;

  ndv_slot_timer #(
    .HOLD_SLOTS  (HOLD_SLOTS),
    .SAMPLE_EVERY(SAMPLE_EVERY)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_en     (fast_en),
    .slot_tick   (slot_tick),
    .holdoff_done(holdoff_done),
    .sample_win  (sample_win)
  );

  ndv_peak_tracker #(
    .CODE_W  (CODE_W),
    .DROP_LSB(DROP_LSB)
  ) u_peak (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .accept   (accept),
    .code     (smp_code),
    .peak     (peak),
    .have_peak(have_peak),
    .new_peak (new_peak),
    .drop_hit (drop_hit)
  );

  ndv_flat_counter #(
    .FLAT_SAMPLES(FLAT_SAMPLES)
  ) u_flat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .accept  (accept),
    .restart (new_peak),
    .flat_cnt(flat_cnt),
    .flat_hit(flat_hit)
  );

  // one accepted strobe per window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          taken <= 1'b0;
    else if (!fast_en)   taken <= 1'b0;
    else if (slot_tick)  taken <= 1'b0;
    else if (accept)     taken <= 1'b1;
  end

  // termination latch and pulse register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      term_q   <= 1'b0;
      reason_q <= NDV_DROP;
    end else begin
      term_q <= accept && (drop_hit || flat_hit);
      if (!fast_en) begin
        done <= 1'b0;
      end else if (accept && (drop_hit || flat_hit)) begin
        done     <= 1'b1;
        reason_q <= drop_hit ? NDV_DROP : NDV_FLAT;
      end
    end
  end

  assign term_o        = term_q && fast_en;
  assign term_reason_o = term_o && (reason_q == NDV_FLAT);

endmodule

// File: rtl/ndv_term_checker.sv
module ndv_term_checker #(
  parameter int CODE_W       = 12,
  parameter int FLAT_SAMPLES = 31,
  localparam int FW = (FLAT_SAMPLES > 2) ? $clog2(FLAT_SAMPLES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fast_en,
  input logic              holdoff_done,
  input logic              accept,
  input logic              done,
  input logic              have_peak,
  input logic [CODE_W-1:0] peak,
  input logic [FW-1:0]     flat_cnt,
  input logic              term_o
);

  // R2: nothing ends the charge before blanking is over
  p_quiet_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !holdoff_done |-> !term_o);

  // R5: every pulse traces back to an accepted sample
  p_term_from_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> $past(accept));

  // R4: peak never decreases within a session
  p_peak_rises_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && have_peak) |=> (!fast_en || peak >= $past(peak)));

  // R6: plateau count stays below its limit
  p_flat_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(flat_cnt) < FLAT_SAMPLES);

  // R9: pulse lasts one cycle and leaves the session latched
  p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |=> !term_o);

  p_latched_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> done);

  // R10: dropping fast charge wipes the tracking state
  p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |=> (!have_peak && flat_cnt == '0 && !done));

endmodule

bind ndv_term_detect ndv_term_checker #(
  .CODE_W      (CODE_W),
  .FLAT_SAMPLES(FLAT_SAMPLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fast_en     (fast_en),
  .holdoff_done(holdoff_done),
  .accept      (accept),
  .done        (done),
  .have_peak   (have_peak),
  .peak        (peak),
  .flat_cnt    (flat_cnt),
  .term_o      (term_o)
);

// File: tb/ndv_term_detect_tb.sv
module ndv_term_detect_tb;
  localparam int CW   = 12;
  localparam int HOLD = 8;
  localparam int SE   = 4;
  localparam int FLAT = 5;
  localparam int DROP = 2;

  // {expect_term, expect_reason, code}
  localparam int NV = 9;
  localparam logic [CW+1:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'd1000},  // first peak
    {1'b0, 1'b0, 12'd1005},  // new peak
    {1'b0, 1'b0, 12'd1004},  // one under: no drop
    {1'b0, 1'b0, 12'd1010},  // new peak restarts plateau
    {1'b0, 1'b0, 12'd1009},
    {1'b0, 1'b0, 12'd1009},
    {1'b0, 1'b0, 12'd1010},  // equal: no restart
    {1'b0, 1'b0, 12'd1009},
    {1'b1, 1'b0, 12'd1008}   // drop and plateau together: drop wins
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fast_en = 1'b0;
  logic          slot_tick = 1'b0;
  logic          smp_valid = 1'b0;
  logic [CW-1:0] smp_code = '0;
  logic          term_o;
  logic          term_reason_o;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ndv_term_detect #(
    .CODE_W(CW), .HOLD_SLOTS(HOLD), .SAMPLE_EVERY(SE),
    .FLAT_SAMPLES(FLAT), .DROP_LSB(DROP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en), .slot_tick(slot_tick),
    .smp_valid(smp_valid), .smp_code(smp_code),
    .term_o(term_o), .term_reason_o(term_reason_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic slot();
    @(negedge clk) slot_tick = 1'b1;
    @(negedge clk) slot_tick = 1'b0;
  endtask

  task automatic strobe(input logic [CW-1:0] v);
    @(negedge clk) begin smp_valid = 1'b1; smp_code = v; end
    @(negedge clk) smp_valid = 1'b0;
  endtask

  task automatic start_session();
    @(negedge clk) fast_en = 1'b0;
    repeat (2) @(negedge clk);
    fast_en = 1'b1;
    repeat (HOLD) slot();
  endtask

  // one full sample period: window, sample, check, close window
  task automatic sample_slot(input logic [CW-1:0] v, input logic et, input logic er,
                             input string tag);
    repeat (SE-1) slot();
    strobe(v);
    check(term_o === et, {tag, " pulse"}, term_o, et);
    if (et) check(term_reason_o === er, {tag, " reason"}, term_reason_o, er);
    @(negedge clk);
    check(term_o === 1'b0, "R9 pulse width", term_o, 0);
    slot();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(term_o === 1'b0, "R1 reset term", term_o, 0);
    check(term_reason_o === 1'b0, "R1 reset reason", term_reason_o, 0);
    rst_n = 1'b1;

    // R1: idle activity with fast_en low
    for (int i = 0; i < 3 * SE; i++) begin
      slot();
      strobe(CW'(i * 300));
      check(term_o === 1'b0, "R1 idle", term_o, 0);
    end

    // R4 R5 R7 R8: table walk in one session
    start_session();
    for (int i = 0; i < NV; i++)
      sample_slot(VEC[i][CW-1:0], VEC[i][CW+1], VEC[i][CW], "R4 R5 R7 R8 table");
    // R9: no second pulse after termination
    sample_slot(12'd100, 1'b0, 1'b0, "R9 after done");

    // R6: plateau
    start_session();
    sample_slot(12'd1000, 1'b0, 1'b0, "R6 peak");
    sample_slot(12'd999,  1'b0, 1'b0, "R6 flat1");
    sample_slot(12'd1000, 1'b0, 1'b0, "R6 flat2");
    sample_slot(12'd999,  1'b0, 1'b0, "R6 flat3");
    sample_slot(12'd1000, 1'b0, 1'b0, "R6 flat4");
    sample_slot(12'd999,  1'b1, 1'b1, "R6 flat5");

    // R2: samples during blanking are discarded
    @(negedge clk) fast_en = 1'b0;
    repeat (2) @(negedge clk);
    fast_en = 1'b1;
    for (int i = 0; i < HOLD; i++) begin
      strobe(12'd2000);
      check(term_o === 1'b0, "R2 blank", term_o, 0);
      slot();
    end
    sample_slot(12'd1000, 1'b0, 1'b0, "R2 first peak");
    sample_slot(12'd998,  1'b1, 1'b0, "R5 exact threshold");

    // R3: out-of-window and second-in-window strobes ignored
    start_session();
    sample_slot(12'd1000, 1'b0, 1'b0, "R3 peak");
    strobe(12'd500);
    check(term_o === 1'b0, "R3 outside window", term_o, 0);
    repeat (SE-1) slot();
    strobe(12'd1000);
    strobe(12'd500);
    check(term_o === 1'b0, "R3 second in window", term_o, 0);
    slot();
    sample_slot(12'd999, 1'b0, 1'b0, "R3 peak kept");
    sample_slot(12'd998, 1'b1, 1'b0, "R3 drop vs kept peak");

    // R10: new session forgets old peak
    start_session();
    sample_slot(12'd500, 1'b0, 1'b0, "R10 fresh peak");
    sample_slot(12'd498, 1'b1, 1'b0, "R10 drop vs fresh peak");

    // R11: pulse gated when fast_en falls
    start_session();
    sample_slot(12'd1000, 1'b0, 1'b0, "R11 peak");
    repeat (SE-1) slot();
    @(negedge clk) begin smp_valid = 1'b1; smp_code = 12'd900; end
    @(negedge clk) begin smp_valid = 1'b0; fast_en = 1'b0; end
    #1 check(term_o === 1'b0, "R11 gated", term_o, 0);
    @(negedge clk);
    check(term_o === 1'b0, "R11 still low", term_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule